// File: doc/BRIEF.md
# Chained DMA Descriptor Sequencer

This block steps through a small table of transfer descriptors kept in a local register array. A host loads each entry. An entry holds a 32-bit local base address, a 64-bit remote base address split into upper and lower words, a length in 32-bit words, and two per-entry enable bits. The host then sets a run bit. The sequencer starts at entry 0. For every entry it presents one request to a data mover and waits for that mover's done strobe. It stops after the last entry that the header count allows.

When an entry completes, the sequencer may record that entry's number in a shared last-completed field of the table. It may also raise a one-cycle interrupt request. Each of these actions is enabled by the entry's own bit ORed with a global bit: the control word's write-back enable for the record, and the header's interrupt enable for the interrupt. An entry of length zero completes without issuing a request. If the run bit is cleared during a run, the transfer in flight finishes and the sequencer then goes idle. The engine only reads descriptor words. The host can read and write all of them.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset, `busy`, `xfer_req` and `irq` are low, and the last-completed field (read select 4) reads 0.
- R2: A rising edge on `ctrl_run` while idle with `hdr_count` nonzero starts a run at entry 0. Entries are processed in ascending order up to `hdr_count`-1. A zero count starts nothing. Holding `ctrl_run` high after a run ends does not start a new run.
- R3: For each entry of nonzero length, `xfer_req` rises with `xfer_laddr` equal to the local word, `xfer_raddr` equal to {upper word, lower word}, and `xfer_len` equal to the length. `xfer_req` stays high until a cycle with `xfer_done` high.
- R4: `busy` is high from the cycle after the start edge until the cycle that follows the final completion.
- R5: When an entry completes with (entry write-back bit OR `ctrl_wb_en`) set, the last-completed field takes that entry's number (0 to n), visible from the next cycle. Otherwise the field keeps its value.
- R6: When an entry completes with (entry interrupt bit OR `hdr_irq_en`) set, `irq` is high for exactly one cycle, the cycle after completion. `irq` is never high in two adjacent cycles.
- R7: An entry of length 0 produces no `xfer_req` but still follows R5 and R6.
- R8: If `ctrl_run` is low when the current entry completes, no further entry is fetched and `busy` falls in the next cycle.
- R9: The engine never alters descriptor words. Host read selects are 0 for the local address, 1 for the remote upper word, 2 for the remote lower word, 3 for {bit 17 interrupt enable, bit 16 write-back enable, bits 15:0 length}, and 4 for the last-completed field. Each returns what the host last wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host write strobe |
| host_widx | input | 3 | Entry written |
| host_wsel | input | 3 | Word written (select codes as in R9) |
| host_wdata | input | 32 | Write data |
| host_ridx | input | 3 | Entry read |
| host_rsel | input | 3 | Word read |
| host_rdata | output | 32 | Read data, combinational |
| ctrl_run | input | 1 | Run bit |
| ctrl_wb_en | input | 1 | Global write-back enable |
| hdr_count | input | 4 | Number of entries to process |
| hdr_irq_en | input | 1 | Global interrupt enable |
| xfer_req | output | 1 | Transfer request to data mover |
| xfer_laddr | output | 32 | Local base address |
| xfer_raddr | output | 64 | Remote base address |
| xfer_len | output | 16 | Length in 32-bit words |
| xfer_done | input | 1 | Data mover completion strobe |
| busy | output | 1 | Run in progress |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench preloads the last-completed field with a sentinel. With the global write-back enable off, only one entry carries the write-back bit, so a design that ANDs the enables, or records every completion, leaves a different number in the field. Runs of all-zero-length entries with the global interrupt on would merge their pulses into a multi-cycle level if completions were not separated. The same runs would also show spurious requests if zero-length entries were sent to the mover. Clearing the run bit during the first transfer catches a design that abandons the transfer in flight or runs on to entry 1. Holding the run bit high after the end catches a design that restarts on a level.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_LADDR = 3'd0;
  localparam logic [SEL_W-1:0] SEL_RHI   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_RLO   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_CTL   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_LAST  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dma_desc_table.sv
module dma_desc_table
  import dma_seq_pkg::*;
#(
  parameter int unsigned N_DESC = 8,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned IDX_W = $clog2(N_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_widx,
  input  logic [SEL_W-1:0]  host_wsel,
  input  logic [ADDR_W-1:0] host_wdata,
  input  logic [IDX_W-1:0]  host_ridx,
  input  logic [SEL_W-1:0]  host_rsel,
  output logic [ADDR_W-1:0] host_rdata,
  input  logic [IDX_W-1:0]  eng_idx,
  output logic [ADDR_W-1:0] eng_laddr,
  output logic [ADDR_W-1:0] eng_rhi,
  output logic [ADDR_W-1:0] eng_rlo,
  output logic [LEN_W-1:0]  eng_len,
  output logic              eng_wb,
  output logic              eng_irq,
  input  logic              wb_we,
  input  logic [IDX_W-1:0]  wb_idx
);
  localparam int unsigned WB_BIT  = LEN_W;
  localparam int unsigned IRQ_BIT = LEN_W + 1;
  localparam int unsigned PAD_W   = ADDR_W - LEN_W - 2;

  logic [ADDR_W-1:0] laddr_q [N_DESC];
  logic [ADDR_W-1:0] rhi_q   [N_DESC];
  logic [ADDR_W-1:0] rlo_q   [N_DESC];
  logic [LEN_W-1:0]  len_q   [N_DESC];
  logic              wb_q    [N_DESC];
  logic              irq_q   [N_DESC];
  logic [IDX_W-1:0]  last_q;
  logic              host_last_we;

  assign host_last_we = host_we && (host_wsel == SEL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_DESC; i++) begin
        laddr_q[i] <= '0;
        rhi_q[i]   <= '0;
        rlo_q[i]   <= '0;
        len_q[i]   <= '0;
        wb_q[i]    <= 1'b0;
        irq_q[i]   <= 1'b0;
      end
    end else if (host_we) begin
      for (int i = 0; i < N_DESC; i++) begin
        if (host_widx == IDX_W'(i)) begin
          if (host_wsel == SEL_LADDR) laddr_q[i] <= host_wdata;
          if (host_wsel == SEL_RHI)   rhi_q[i]   <= host_wdata;
          if (host_wsel == SEL_RLO)   rlo_q[i]   <= host_wdata;
          if (host_wsel == SEL_CTL) begin
            len_q[i] <= host_wdata[LEN_W-1:0];
            wb_q[i]  <= host_wdata[WB_BIT];
            irq_q[i] <= host_wdata[IRQ_BIT];
          end
        end
      end
    end
  end

  // engine record takes priority over a colliding host write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            last_q <= '0;
    else if (wb_we)        last_q <= wb_idx;
    else if (host_last_we) last_q <= host_wdata[IDX_W-1:0];
  end

  assign eng_laddr = laddr_q[eng_idx];
  assign eng_rhi   = rhi_q[eng_idx];
  assign eng_rlo   = rlo_q[eng_idx];
  assign eng_len   = len_q[eng_idx];
  assign eng_wb    = wb_q[eng_idx];
  assign eng_irq   = irq_q[eng_idx];

  always_comb begin
    case (host_rsel)
      SEL_LADDR: host_rdata = laddr_q[host_ridx];
      SEL_RHI:   host_rdata = rhi_q[host_ridx];
      SEL_RLO:   host_rdata = rlo_q[host_ridx];
      SEL_CTL:   host_rdata = {{PAD_W{1'b0}}, irq_q[host_ridx], wb_q[host_ridx], len_q[host_ridx]};
      SEL_LAST:  host_rdata = {{(ADDR_W-IDX_W){1'b0}}, last_q};
      default:   host_rdata = '0;
    endcase
  end

  // R9
  last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_we && !host_last_we) |=> $stable(last_q));

  // R5
  wb_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |=> (last_q == $past(wb_idx)));
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int unsigned N_DESC = 8,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned IDX_W = $clog2(N_DESC),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_run,
  input  logic             ctrl_wb_en,
  input  logic [CNT_W-1:0] hdr_count,
  input  logic             hdr_irq_en,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             desc_wb,
  input  logic             desc_irq,
  input  logic             xfer_done,
  output logic [IDX_W-1:0] idx,
  output logic             xfer_req,
  output logic             busy,
  output logic             irq,
  output logic             wb_we,
  output logic [IDX_W-1:0] wb_idx
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             run_q;
  logic             irq_q, irq_d;
  logic             start, zero_len, cmpl, last_desc;

  assign start     = ctrl_run && !run_q && (hdr_count != '0);
  assign zero_len  = (desc_len == '0);
  assign cmpl      = ((state_q == ST_LAUNCH) && zero_len) ||
                     ((state_q == ST_WAIT) && xfer_done);
  assign last_desc = ((CNT_W'(idx_q) + 1'b1) >= hdr_count) ||
                     (idx_q == IDX_W'(N_DESC - 1));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_LAUNCH;
        idx_d   = '0;
        idx_en  = 1'b1;
      end
      ST_LAUNCH: state_d = zero_len ? ST_DONE : ST_WAIT;
      ST_WAIT:   if (xfer_done) state_d = ST_DONE;
      ST_DONE: begin
        if (last_desc || !ctrl_run) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_LAUNCH;
          idx_d   = idx_q + 1'b1;
          idx_en  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign irq_d = cmpl && (desc_irq || hdr_irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      run_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= ctrl_run;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx      = idx_q;
  assign xfer_req = (state_q == ST_WAIT);
  assign busy     = (state_q != ST_IDLE);
  assign irq      = irq_q;
  assign wb_we    = cmpl && (desc_wb || ctrl_wb_en);
  assign wb_idx   = idx_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> xfer_req);

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_LAUNCH) && zero_len) |=> !xfer_req);

  // R8
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DONE) && !ctrl_run) |=> !busy);

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrl_run));
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned N_DESC = 8,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned IDX_W = $clog2(N_DESC),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_we,
  input  logic [IDX_W-1:0]    host_widx,
  input  logic [SEL_W-1:0]    host_wsel,
  input  logic [ADDR_W-1:0]   host_wdata,
  input  logic [IDX_W-1:0]    host_ridx,
  input  logic [SEL_W-1:0]    host_rsel,
  output logic [ADDR_W-1:0]   host_rdata,
  input  logic                ctrl_run,
  input  logic                ctrl_wb_en,
  input  logic [CNT_W-1:0]    hdr_count,
  input  logic                hdr_irq_en,
  output logic                xfer_req,
  output logic [ADDR_W-1:0]   xfer_laddr,
  output logic [2*ADDR_W-1:0] xfer_raddr,
  output logic [LEN_W-1:0]    xfer_len,
  input  logic                xfer_done,
  output logic                busy,
  output logic                irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [IDX_W-1:0]  cur_idx, wb_idx;
  logic [ADDR_W-1:0] cur_laddr, cur_rhi, cur_rlo;
  logic [LEN_W-1:0]  cur_len;
  logic              cur_wb, cur_irq, wb_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dma_desc_table #(.N_DESC(N_DESC), .LEN_W(LEN_W)) u_table (
    .clk(clk), .rst_n(rst_int_n),
    .host_we(host_we), .host_widx(host_widx), .host_wsel(host_wsel),
    .host_wdata(host_wdata), .host_ridx(host_ridx), .host_rsel(host_rsel),
    .host_rdata(host_rdata), .eng_idx(cur_idx), .eng_laddr(cur_laddr),
    .eng_rhi(cur_rhi), .eng_rlo(cur_rlo), .eng_len(cur_len),
    .eng_wb(cur_wb), .eng_irq(cur_irq), .wb_we(wb_we), .wb_idx(wb_idx)
  );

  dma_seq_ctrl #(.N_DESC(N_DESC), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .ctrl_run(ctrl_run), .ctrl_wb_en(ctrl_wb_en), .hdr_count(hdr_count),
    .hdr_irq_en(hdr_irq_en), .desc_len(cur_len), .desc_wb(cur_wb),
    .desc_irq(cur_irq), .xfer_done(xfer_done), .idx(cur_idx),
    .xfer_req(xfer_req), .busy(busy), .irq(irq), .wb_we(wb_we), .wb_idx(wb_idx)
  );

  assign xfer_laddr = cur_laddr;
  assign xfer_raddr = {cur_rhi, cur_rlo};
  assign xfer_len   = cur_len;
endmodule

// File: tb/tb_dma_desc_seq.sv
module tb_dma_desc_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] la;
    logic [63:0] ra;
    logic [15:0] len;
  } xfer_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_widx = '0, host_ridx = '0;
  logic [2:0]  host_wsel = '0, host_rsel = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        ctrl_run = 1'b0, ctrl_wb_en = 1'b0, hdr_irq_en = 1'b0;
  logic [3:0]  hdr_count = '0;
  logic        xfer_req, xfer_done = 1'b0, busy, irq;
  logic [31:0] xfer_laddr;
  logic [63:0] xfer_raddr;
  logic [15:0] xfer_len;

  int checks = 0, errors = 0;
  int irq_cnt = 0, lat = 3, stub_cnt = 0;
  bit req_seen = 0, prev_irq = 0, mon_on = 0, done_flag = 0;
  xfer_t exp_q[$];

  logic [31:0] m_la [8], m_hi [8], m_lo [8];
  logic [15:0] m_len [8];
  logic        m_wb [8], m_irq [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_desc_seq dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_widx(host_widx),
    .host_wsel(host_wsel), .host_wdata(host_wdata), .host_ridx(host_ridx),
    .host_rsel(host_rsel), .host_rdata(host_rdata), .ctrl_run(ctrl_run),
    .ctrl_wb_en(ctrl_wb_en), .hdr_count(hdr_count), .hdr_irq_en(hdr_irq_en),
    .xfer_req(xfer_req), .xfer_laddr(xfer_laddr), .xfer_raddr(xfer_raddr),
    .xfer_len(xfer_len), .xfer_done(xfer_done), .busy(busy), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // data mover stub
  always @(negedge clk) begin
    if (xfer_done) xfer_done <= 1'b0;
    else if (xfer_req) begin
      if (stub_cnt >= lat) begin xfer_done <= 1'b1; stub_cnt <= 0; end
      else stub_cnt <= stub_cnt + 1;
    end
  end

  // monitor: pops expected transfers, counts irq pulses
  always @(negedge clk) begin
    if (mon_on) begin
      if (xfer_req && !req_seen) begin
        req_seen = 1;
        if (exp_q.size() == 0) check(0, "R7 unexpected request", {32'd0, xfer_laddr}, 64'd0);
        else begin
          xfer_t e;
          e = exp_q.pop_front();
          check(xfer_laddr == e.la, "R3 local address", {32'd0, xfer_laddr}, {32'd0, e.la});
          check(xfer_raddr == e.ra, "R3 remote address", xfer_raddr, e.ra);
          check(xfer_len == e.len, "R3 length", {48'd0, xfer_len}, {48'd0, e.len});
        end
      end
      if (!xfer_req) req_seen = 0;
      if (irq) begin
        irq_cnt++;
        if (prev_irq) check(0, "R6 irq adjacent cycles", 64'd1, 64'd0);
      end
      prev_irq = irq;
    end
  end

  task automatic hwrite(input int idx, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_widx = 3'(idx); host_wsel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input int idx, input logic [2:0] sel, output logic [31:0] d);
    host_ridx = 3'(idx); host_rsel = sel;
    #1 d = host_rdata;
  endtask

  task automatic load(input int i, input logic [31:0] la, input logic [31:0] hi,
                      input logic [31:0] lo, input logic [15:0] len, input bit wb, input bit ir);
    m_la[i] = la; m_hi[i] = hi; m_lo[i] = lo; m_len[i] = len; m_wb[i] = wb; m_irq[i] = ir;
    hwrite(i, 3'd0, la);
    hwrite(i, 3'd1, hi);
    hwrite(i, 3'd2, lo);
    hwrite(i, 3'd3, {14'd0, ir, wb, len});
  endtask

  // driver: pushes expected items, runs the table, checks outcome
  task automatic run_seq(input string tag, input int cnt, input bit hirq, input bit gwb,
                         input int stop_at, input logic [31:0] exp_last);
    int n, exp_irq;
    logic [31:0] rd;
    n = (stop_at > 0) ? 1 : cnt;
    exp_irq = 0;
    for (int i = 0; i < n; i++) begin
      if (m_len[i] != 0) exp_q.push_back({m_la[i], m_hi[i], m_lo[i], m_len[i]});
      if (m_irq[i] || hirq) exp_irq++;
    end
    @(negedge clk);
    irq_cnt = 0;
    ctrl_wb_en = gwb; hdr_irq_en = hirq; hdr_count = 4'(cnt); ctrl_run = 1'b1;
    @(negedge clk);
    check(busy == (cnt > 0), {tag, " R4 busy after start"}, {63'd0, busy}, {63'd0, cnt > 0});
    if (stop_at > 0) begin
      repeat (stop_at) @(negedge clk);
      ctrl_run = 1'b0;
    end
    while (busy) @(negedge clk);
    if (stop_at == 0) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(!busy, {tag, " R2 no restart while run held"}, {63'd0, busy}, 64'd0);
      end
    end
    ctrl_run = 1'b0;
    @(negedge clk);
    check(exp_q.size() == 0, {tag, " R3 all transfers issued"}, 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    check(irq_cnt == exp_irq, {tag, " R6 irq count"}, 64'(irq_cnt), 64'(exp_irq));
    hread(0, 3'd4, rd);
    check(rd == exp_last, {tag, " R5 last completed"}, {32'd0, rd}, {32'd0, exp_last});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!busy, "R1 busy", {63'd0, busy}, 64'd0);
    check(!xfer_req, "R1 xfer_req", {63'd0, xfer_req}, 64'd0);
    check(!irq, "R1 irq", {63'd0, irq}, 64'd0);
    hread(0, 3'd4, rd);
    check(rd == 0, "R1 last field", {32'd0, rd}, 64'd0);
    mon_on = 1;

    load(0, 32'h1000_0000, 32'h0000_00AB, 32'h2000_0000, 16'd4, 1'b0, 1'b0);
    load(1, 32'h1000_0100, 32'h0000_0000, 32'h3000_0040, 16'd1, 1'b1, 1'b0);
    load(2, 32'h1000_0200, 32'hFFFF_0001, 32'h4000_0080, 16'd7, 1'b0, 1'b1);
    load(3, 32'h1000_0300, 32'h0000_0012, 32'h5000_00C0, 16'd2, 1'b0, 1'b0);

    // R2 global enables on: every entry records and interrupts
    run_seq("t_global", 3, 1'b1, 1'b1, 0, 32'd2);

    // R5 R6 per-entry bits only
    hwrite(0, 3'd4, 32'd7);
    run_seq("t_entry", 3, 1'b0, 1'b0, 0, 32'd1);

    // R7 zero length in the middle, still records and interrupts
    load(1, 32'h1000_0100, 32'h0000_0000, 32'h3000_0040, 16'd0, 1'b1, 1'b1);
    hwrite(0, 3'd4, 32'd7);
    lat = 1;
    run_seq("t_zero_mid", 3, 1'b0, 1'b0, 0, 32'd1);

    // R7 R6 all zero length with global interrupt
    for (int i = 0; i < 4; i++) load(i, m_la[i], m_hi[i], m_lo[i], 16'd0, 1'b0, 1'b0);
    run_seq("t_zero_all", 4, 1'b1, 1'b1, 0, 32'd3);

    // R8 stop mid-run: only entry 0 completes
    load(0, 32'h1000_0000, 32'h0000_00AB, 32'h2000_0000, 16'd4, 1'b0, 1'b0);
    load(1, 32'h1000_0100, 32'h0000_0000, 32'h3000_0040, 16'd3, 1'b0, 1'b0);
    lat = 8;
    run_seq("t_stop", 4, 1'b0, 1'b1, 2, 32'd0);

    // R2 zero count starts nothing
    hwrite(0, 3'd4, 32'd5);
    run_seq("t_count0", 0, 1'b1, 1'b1, 0, 32'd5);

    // R9 descriptor words unchanged by the engine
    for (int i = 0; i < 4; i++) begin
      hread(i, 3'd0, rd); check(rd == m_la[i], "R9 local word", {32'd0, rd}, {32'd0, m_la[i]});
      hread(i, 3'd1, rd); check(rd == m_hi[i], "R9 upper word", {32'd0, rd}, {32'd0, m_hi[i]});
      hread(i, 3'd2, rd); check(rd == m_lo[i], "R9 lower word", {32'd0, rd}, {32'd0, m_lo[i]});
      hread(i, 3'd3, rd);
      check(rd == {14'd0, m_irq[i], m_wb[i], m_len[i]}, "R9 control word",
            {32'd0, rd}, {32'd0, 14'd0, m_irq[i], m_wb[i], m_len[i]});
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule